// File: doc/BRIEF.md
# Streaming Coefficient Merge Unit

This block turns a stream of wide convolution coefficients into the words of a multi-word integer product. Each coefficient is three result words wide, and it is produced by an upstream multiply-accumulate stage. The unit forms one result word per coefficient as the coefficient arrives. It adds the low field of the new coefficient, the middle field of the one before, the high field of the one before that, and a small carry held from the previous step. Only the low W bits of that sum leave the block. The bits above them stay in a register for the next step, so the unit never performs an addition as wide as the whole result.

The same merge path also serves long addition and long subtraction. In those modes the coefficient input is ignored. Two operand words per cycle go straight into the adder together with a carry, and for subtraction the second operand is inverted with an initial carry of one. After the last coefficient of a product, the unit outputs two tail words that drain the held fields. After the last word of a sum, it outputs one tail word holding the final carry. At the end of a difference it raises a borrow flag instead.

Top module: `coef_merge_unit`

## Requirements
- R1: Mode is selected by `mode_sel`: 2'b00 multiply-merge, 2'b01 add, 2'b10 subtract. In multiply-merge mode the coefficient fields are low = bits [W-1:0], middle = bits [2W-1:W] and high = bits [3W-1:2W]. Result word i is the low W bits of low(C[i]) + middle(C[i-1]) + high(C[i-2]) + carry. Fields of coefficients before the first one of an operation count as zero.
- R2: Each accepted input word (`in_valid` high) yields exactly one output word with `out_valid` high one clock later. There is no back-pressure.
- R3: The carry kept between steps holds the sum bits above W. It never exceeds 3 in multiply-merge mode and never exceeds 1 in add or subtract mode.
- R4: After the last coefficient (`in_last`), the two following cycles each output one tail word: first middle(C[n-1]) + high(C[n-2]) + carry, then high(C[n-1]) + carry. `out_last` is high only on the second tail word. No input may arrive during the tail.
- R5: In add mode each output word is the low W bits of A[i] + B[i] + carry, starting from carry 0. The cycle after the last input word outputs one extra word equal to the final carry (0 or 1), marked with `out_last`.
- R6: In subtract mode each output word is the low W bits of A[i] + ~B[i] + carry, starting from carry 1. The word for the last input carries `out_last`, and `out_borrow` is 1 on that word exactly when A < B.
- R7: `out_borrow` is 0 on every word other than the final word of a subtraction.
- R8: After the final word of an operation, all held fields and the carry are cleared. An operation that starts on the very next cycle behaves as if it started from reset.
- R9: While and after reset, before any input, `out_valid`, `out_last` and `out_borrow` are 0.
- R10: With W = 16, merging the coefficients of 987654321 × 98765 yields the 16-bit words of 97545679013565.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Operation select: 00 multiply-merge, 01 add, 10 subtract |
| in_valid | input | 1 | Input word present this cycle |
| in_last | input | 1 | Marks the final input word of an operation |
| coef_in | input | 3*W | Coefficient for multiply-merge mode |
| opa_in | input | W | First operand word for add/subtract |
| opb_in | input | W | Second operand word for add/subtract |
| out_valid | output | 1 | Result word present |
| out_last | output | 1 | Final result word of the operation |
| out_word | output | W | Result word, least significant first |
| out_borrow | output | 1 | Subtraction result negative, valid with out_last |

## Verification
The assertions take for granted that the producer stays silent during the tail cycles of a product or a sum. They also assume `mode_sel` does not change between the first and last word of an operation, and two checks in the controller flag any input that breaks either rule. The directed stimulus leaves a gap of several idle cycles after every multiply-merge or add operation. It holds the mode constant for the whole of each operation. It sends back-to-back words only where the requirements allow, which is after a subtraction ends, since a subtraction has no tail.

// File: rtl/merge_pkg.sv
package merge_pkg;

    localparam int CARRY_W = 2;

    typedef enum logic [1:0] {
        MD_MUL = 2'b00,
        MD_ADD = 2'b01,
        MD_SUB = 2'b10
    } merge_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_TAIL_A,
        ST_TAIL_B
    } merge_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_COEF,
        K_TAIL_A,
        K_TAIL_B,
        K_ADD,
        K_SUB,
        K_CARRY
    } step_kind_e;

    typedef struct packed {
        step_kind_e kind;
        logic       first;
        logic       final_w;
    } step_cmd_t;

    function automatic logic is_arith(input logic [1:0] m);
        return (m == MD_ADD) || (m == MD_SUB);
    endfunction

endpackage

// File: rtl/merge_sum3.sv
module merge_sum3 #(
    parameter int W  = 32,
    parameter int CW = 2
) (
    input  logic [W-1:0]  x,
    input  logic [W-1:0]  y,
    input  logic [W-1:0]  z,
    input  logic [CW-1:0] cin,
    output logic [W-1:0]  word,
    output logic [CW-1:0] cout
);
    localparam int SW = W + CW;

    logic [SW-1:0] total;

    always_comb begin
        total = {{CW{1'b0}}, x} + {{CW{1'b0}}, y} + {{CW{1'b0}}, z}
              + {{W{1'b0}}, cin};
        word  = total[W-1:0];
        cout  = total[SW-1:W];
    end
endmodule

// File: rtl/merge_ctrl.sv
module merge_ctrl
    import merge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       in_valid,
    input  logic       in_last,
    output step_cmd_t  cmd
);
    merge_state_e state, state_nxt;
    logic [1:0]   mode_r;

    always_comb begin
        cmd.kind    = K_NONE;
        cmd.first   = 1'b0;
        cmd.final_w = 1'b0;
        state_nxt   = state;
        case (state)
            ST_IDLE, ST_RUN: begin
                if (in_valid) begin
                    cmd.first = (state == ST_IDLE);
                    if (mode_sel == MD_ADD)      cmd.kind = K_ADD;
                    else if (mode_sel == MD_SUB) cmd.kind = K_SUB;
                    else                         cmd.kind = K_COEF;
                    if (in_last) begin
                        if (mode_sel == MD_SUB) begin
                            cmd.final_w = 1'b1;
                            state_nxt   = ST_IDLE;
                        end else begin
                            state_nxt   = ST_TAIL_A;
                        end
                    end else begin
                        state_nxt = ST_RUN;
                    end
                end
            end
            ST_TAIL_A: begin
                if (mode_r == MD_ADD) begin
                    cmd.kind    = K_CARRY;
                    cmd.final_w = 1'b1;
                    state_nxt   = ST_IDLE;
                end else begin
                    cmd.kind    = K_TAIL_A;
                    state_nxt   = ST_TAIL_B;
                end
            end
            default: begin
                cmd.kind    = K_TAIL_B;
                cmd.final_w = 1'b1;
                state_nxt   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_r <= MD_MUL;
        end else begin
            state <= state_nxt;
            if (in_valid && (state == ST_IDLE || state == ST_RUN))
                mode_r <= mode_sel;
        end
    end

    // R4: input assumption, the producer stays quiet while the tail drains
    p_quiet_tail_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TAIL_A || state == ST_TAIL_B) |-> !in_valid);

    // R1: input assumption, the mode is held for the whole operation
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && in_valid) |-> (mode_sel == mode_r));
endmodule

// File: rtl/merge_datapath.sv
module merge_datapath
    import merge_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  step_cmd_t     cmd,
    input  logic [3*W-1:0] coef,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic          out_valid,
    output logic          out_last,
    output logic [W-1:0]  out_word,
    output logic          out_borrow
);
    localparam int NFLD = 3;

    logic [W-1:0]       fld [NFLD];
    logic [W-1:0]       mid_r, hi1_r, hi2_r;
    logic [CARRY_W-1:0] carry_r;
    logic [W-1:0]       ax, ay, az;
    logic [CARRY_W-1:0] acin;
    logic [W-1:0]       sum_word;
    logic [CARRY_W-1:0] sum_cout;

    for (genvar g = 0; g < NFLD; g++) begin : g_field
        assign fld[g] = coef[g*W +: W];
    end

    always_comb begin
        ax   = '0;
        ay   = '0;
        az   = '0;
        acin = carry_r;
        case (cmd.kind)
            K_COEF: begin
                ax = fld[0];
                ay = mid_r;
                az = hi2_r;
            end
            K_TAIL_A: begin
                ay = mid_r;
                az = hi2_r;
            end
            K_TAIL_B: begin
                az = hi2_r;
            end
            K_ADD: begin
                ax = opa;
                ay = opb;
            end
            K_SUB: begin
                ax = opa;
                ay = ~opb;
                if (cmd.first) acin = {{(CARRY_W-1){1'b0}}, 1'b1};
            end
            default: ;
        endcase
    end

    merge_sum3 #(.W(W), .CW(CARRY_W)) u_sum (
        .x    (ax),
        .y    (ay),
        .z    (az),
        .cin  (acin),
        .word (sum_word),
        .cout (sum_cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            out_word   <= '0;
            out_borrow <= 1'b0;
            mid_r      <= '0;
            hi1_r      <= '0;
            hi2_r      <= '0;
            carry_r    <= '0;
        end else begin
            out_valid  <= (cmd.kind != K_NONE);
            out_last   <= cmd.final_w;
            out_word   <= sum_word;
            out_borrow <= cmd.final_w && (cmd.kind == K_SUB) && !sum_cout[0];
            if (cmd.final_w) begin
                mid_r   <= '0;
                hi1_r   <= '0;
                hi2_r   <= '0;
                carry_r <= '0;
            end else begin
                case (cmd.kind)
                    K_COEF: begin
                        hi2_r   <= hi1_r;
                        hi1_r   <= fld[2];
                        mid_r   <= fld[1];
                        carry_r <= sum_cout;
                    end
                    K_TAIL_A: begin
                        hi2_r   <= hi1_r;
                        hi1_r   <= '0;
                        mid_r   <= '0;
                        carry_r <= sum_cout;
                    end
                    K_ADD, K_SUB: carry_r <= sum_cout;
                    default: ;
                endcase
            end
        end
    end

    // R7: the borrow flag only ever accompanies a final word
    p_borrow_last_r7: assert property (@(posedge clk) disable iff (rst)
        out_borrow |-> out_last);

    // R8: nothing held survives the final word of an operation
    p_clear_after_final_r8: assert property (@(posedge clk) disable iff (rst)
        $past(cmd.final_w) |-> (carry_r == '0 && mid_r == '0 &&
                                hi1_r == '0 && hi2_r == '0));

    // R3: a word-by-word add or subtract never carries more than one
    p_arith_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == K_ADD || cmd.kind == K_SUB || cmd.kind == K_CARRY)
            |-> (carry_r <= 2'd1));
endmodule

// File: rtl/coef_merge_unit.sv
module coef_merge_unit
    import merge_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     mode_sel,
    input  logic           in_valid,
    input  logic           in_last,
    input  logic [3*W-1:0] coef_in,
    input  logic [W-1:0]   opa_in,
    input  logic [W-1:0]   opb_in,
    output logic           out_valid,
    output logic           out_last,
    output logic [W-1:0]   out_word,
    output logic           out_borrow
);
    step_cmd_t cmd;

    merge_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .in_valid (in_valid),
        .in_last  (in_last),
        .cmd      (cmd)
    );

    merge_datapath #(.W(W)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .coef       (coef_in),
        .opa        (opa_in),
        .opb        (opb_in),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .out_word   (out_word),
        .out_borrow (out_borrow)
    );

    // R2: every accepted word produces a result word on the next cycle
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R4: a product ends with two tail words, the second one marked last
    p_mul_tail_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && mode_sel == MD_MUL)
            |=> (out_valid && !out_last) ##1 (out_valid && !out_last)
                ##1 (out_valid && out_last));

    // R5: a sum ends with one carry word marked last
    p_add_tail_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && mode_sel == MD_ADD)
            |=> (out_valid && !out_last) ##1 (out_valid && out_last));

    // R6: a difference ends on the word of its last input
    p_sub_end_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && mode_sel == MD_SUB) |=> (out_valid && out_last));
endmodule

// File: tb/coef_merge_unit_bench.sv
`timescale 1ns/1ps
module coef_merge_unit_bench;
    localparam int W = 16;
    localparam longint unsigned MASK = 64'hFFFF;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [1:0]     mode_sel = 2'b00;
    logic           in_valid = 1'b0;
    logic           in_last = 1'b0;
    logic [3*W-1:0] coef_in = '0;
    logic [W-1:0]   opa_in = '0;
    logic [W-1:0]   opb_in = '0;
    logic           out_valid, out_last, out_borrow;
    logic [W-1:0]   out_word;

    coef_merge_unit #(.W(W)) u_coef_merge_unit (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_valid(in_valid),
        .in_last(in_last), .coef_in(coef_in), .opa_in(opa_in), .opb_in(opb_in),
        .out_valid(out_valid), .out_last(out_last), .out_word(out_word),
        .out_borrow(out_borrow)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    longint unsigned a_w [16];
    longint unsigned b_w [16];
    longint unsigned exp_w [40];
    longint unsigned got_w [40];
    logic            got_last [40];
    logic            got_borrow [40];
    int              got_n = 0;

    always @(negedge clk) begin
        if (!rst && out_valid && got_n < 40) begin
            got_w[got_n]      = longint'(out_word);
            got_last[got_n]   = out_last;
            got_borrow[got_n] = out_borrow;
            got_n++;
        end
    end

    task automatic chk(input string req, input longint unsigned act,
                       input longint unsigned expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic step_in;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_wait(input int cyc);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (cyc) step_in();
    endtask

    // compare collected words; last_idx marks the only out_last word
    task automatic compare(input string req, input int cnt, input int borrow_exp);
        chk({req, " word count"}, longint'(got_n), longint'(cnt));
        for (int k = 0; k < cnt && k < got_n; k++) begin
            chk({req, " word"}, got_w[k], exp_w[k]);
            chk({req, " last flag R4"}, longint'(got_last[k]),
                longint'(k == cnt - 1));
            chk({req, " borrow R7"}, longint'(got_borrow[k]),
                (k == cnt - 1) ? longint'(borrow_exp) : 64'd0);
        end
    endtask

    task automatic send_mul(input int n, input int m);
        got_n = 0;
        for (int k = 0; k <= n + m - 2; k++) begin
            longint unsigned c;
            c = 0;
            for (int i = 0; i < n; i++)
                if (k - i >= 0 && k - i < m) c += a_w[i] * b_w[k - i];
            mode_sel = 2'b00;
            in_valid = 1'b1;
            in_last  = (k == n + m - 2);
            coef_in  = c[3*W-1:0];
            opa_in   = '0;
            opb_in   = '0;
            step_in();
        end
        idle_wait(6);
    endtask

    task automatic mul_model(input int n, input int m);
        for (int k = 0; k < 40; k++) exp_w[k] = 0;
        for (int i = 0; i < n; i++) begin
            longint unsigned cy, t;
            int p;
            cy = 0;
            for (int j = 0; j < m; j++) begin
                t = exp_w[i + j] + a_w[i] * b_w[j] + cy;
                exp_w[i + j] = t & MASK;
                cy = t >> W;
            end
            p = i + m;
            while (cy != 0 && p < 40) begin
                t = exp_w[p] + cy;
                exp_w[p] = t & MASK;
                cy = t >> W;
                p++;
            end
        end
    endtask

    // R1, R4: general product against a schoolbook model
    task automatic test_mul(input string tag, input int n, input int m);
        mul_model(n, m);
        send_mul(n, m);
        compare({"R1 ", tag}, n + m + 1, 0);
    endtask

    // R10: the decimal example expressed in 16-bit words
    task automatic test_example;
        longint unsigned prod;
        a_w[0] = 64'h68B1; a_w[1] = 64'h3ADE;
        b_w[0] = 64'h81CD; b_w[1] = 64'h0001;
        prod = 64'd97545679013565;
        for (int k = 0; k < 5; k++) exp_w[k] = (prod >> (16 * k)) & MASK;
        send_mul(2, 2);
        compare("R10 example", 5, 0);
    endtask

    // R5 / R6: word-wise add or subtract of n words
    task automatic test_arith(input string tag, input bit sub, input int n);
        longint unsigned cy, t;
        cy = sub ? 1 : 0;
        for (int k = 0; k < n; k++) begin
            t = a_w[k] + (sub ? (MASK ^ b_w[k]) : b_w[k]) + cy;
            exp_w[k] = t & MASK;
            cy = t >> W;
        end
        if (!sub) exp_w[n] = cy;
        got_n = 0;
        for (int k = 0; k < n; k++) begin
            mode_sel = sub ? 2'b10 : 2'b01;
            in_valid = 1'b1;
            in_last  = (k == n - 1);
            coef_in  = {3{16'hDEAD}};
            opa_in   = a_w[k][W-1:0];
            opb_in   = b_w[k][W-1:0];
            step_in();
        end
        idle_wait(5);
        compare(tag, sub ? n : n + 1, (sub && cy == 0) ? 1 : 0);
    endtask

    // R8: a sum starts the cycle after a difference that left its carry set
    task automatic test_back_to_back;
        got_n = 0;
        mode_sel = 2'b10; in_valid = 1'b1; in_last = 1'b1;
        opa_in = 16'd5; opb_in = 16'd3;
        step_in();
        mode_sel = 2'b01; in_valid = 1'b1; in_last = 1'b1;
        opa_in = 16'd1; opb_in = 16'd1;
        step_in();
        idle_wait(5);
        chk("R8 count", longint'(got_n), 64'd3);
        chk("R6 sub word", got_w[0], 64'd2);
        chk("R6 sub last", longint'(got_last[0]), 64'd1);
        chk("R6 sub no borrow", longint'(got_borrow[0]), 64'd0);
        chk("R8 add word fresh carry", got_w[1], 64'd2);
        chk("R8 add carry word", got_w[2], 64'd0);
        chk("R8 add last", longint'(got_last[2]), 64'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) step_in();
        // R9: reset state
        chk("R9 out_valid", longint'(out_valid), 64'd0);
        chk("R9 out_last", longint'(out_last), 64'd0);
        chk("R9 out_borrow", longint'(out_borrow), 64'd0);
        rst = 1'b0;
        step_in();
        chk("R9 idle after reset", longint'(out_valid), 64'd0);

        test_example();

        // R3: all-ones operands drive the carry to its upper range
        for (int k = 0; k < 4; k++) begin a_w[k] = MASK; b_w[k] = MASK; end
        test_mul("R3 all ones 4x4", 4, 4);

        a_w[0] = 64'h1234; b_w[0] = 64'hFEDC;
        test_mul("R4 single coefficient", 1, 1);

        for (int k = 0; k < 5; k++) a_w[k] = (64'h9E37 * (k + 3)) & MASK;
        for (int k = 0; k < 3; k++) b_w[k] = (64'h7F4A * (k + 5)) & MASK;
        test_mul("R1 uneven 5x3", 5, 3);

        for (int k = 0; k < 4; k++) begin
            a_w[k] = (64'hA5A5 + 64'h1111 * k) & MASK;
            b_w[k] = (64'h6C3B * (k + 1)) & MASK;
        end
        test_arith("R5 add mixed", 1'b0, 4);

        for (int k = 0; k < 3; k++) begin a_w[k] = MASK; b_w[k] = 0; end
        b_w[0] = 1;
        test_arith("R5 add ripple carry out", 1'b0, 3);

        a_w[0] = 64'h0010; a_w[1] = 64'h8000; a_w[2] = 64'h0003;
        b_w[0] = 64'h0020; b_w[1] = 64'h7FFF; b_w[2] = 64'h0001;
        test_arith("R6 sub positive", 1'b1, 3);

        a_w[0] = 64'h0005; a_w[1] = 64'h0001;
        b_w[0] = 64'h0004; b_w[1] = 64'h0002;
        test_arith("R6 sub negative borrow", 1'b1, 2);

        test_back_to_back();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule